// File: doc/BRIEF.md
# Sequenced Serial ADC Host Controller

This block runs the host end of a 16-clock serial link to an eight-input, 12-bit converter. It drives an active-low select and a serial clock made from the system clock by a programmable divider. In each frame it shifts an 8-bit control word out to the converter, carrying a 3-bit input address. It also shifts the converted value back in and presents the result as one tagged sample on a valid/ready output.

The converter works one frame behind: the address sent in one frame picks the input converted in the following frame. The first frame after select falls always converts input address 0. The controller walks a table of up to `NUM_SLOTS` channel addresses and labels every result with the input that was actually converted in that frame. While `enable` stays high, select stays low and frames follow one another. When `enable` falls, the current frame completes and then select rises.

Top module: `adc_seq_host`

## Requirements
- R1: `cs_n` is high after reset and between bursts, and `sclk` is high whenever `cs_n` is high. Every frame has exactly 16 `sclk` low-high cycles, all with `cs_n` low.
- R2: Each `sclk` low phase and each high phase lasts `div_half`+1 system clocks, so one `sclk` period is 2*(`div_half`+1) system clocks.
- R3: During the first 8 `sclk` cycles of a frame, `mosi` carries the control word MSB first. Word bits 5:3 hold the channel address and bits 7, 6, 2, 1, 0 are driven 0. `mosi` is 0 for the last 8 cycles.
- R4: `mosi` changes only together with a falling `sclk`. `miso` is sampled on the system clock edge at which `sclk` rises.
- R5: Of the 16 bits received MSB first in a frame, the first 4 are discarded. The last 12 form `smp_data`, with the first received of these as its MSB.
- R6: The first sample of each burst (the first frame after `cs_n` falls) is tagged with channel 0.
- R7: Every later sample is tagged with the address that was sent in the previous frame of the same burst.
- R8: Frames send the addresses of table slots 0, 1, … `seq_len` in turn and then wrap to slot 0. Slot i is `seq_chans[3i+2:3i]`. Every burst starts again at slot 0.
- R9: A presented sample keeps `smp_valid`, `smp_data` and `smp_chan` steady until it is taken with `smp_ready`. No new frame starts while a sample is waiting, and `cs_n` stays low during that wait.
- R10: When `enable` falls, the frame in progress completes with all 16 cycles, and then `cs_n` returns high.
- R11: While reset is applied, `cs_n`=1, `sclk`=1, `mosi`=0 and `smp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run frames while high |
| div_half | input | DIV_W | Serial clock half-period minus one, in system clocks |
| seq_len | input | $clog2(NUM_SLOTS) | Index of the last table slot used |
| seq_chans | input | NUM_SLOTS*3 | Channel address table, slot i at bits 3i+2:3i |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low converter select |
| sclk | output | 1 | Serial clock, idle high |
| mosi | output | 1 | Serial control data to the converter |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Sample taken when high with smp_valid |
| smp_data | output | 12 | Converted value |
| smp_chan | output | 3 | Input address the value was converted from |

## Verification
The serial results are due at fixed points. Each control bit is valid by the rise of its `sclk` cycle and holds through the high phase. A sample is presented one system clock after the high phase of the sixteenth cycle ends. The bench acts as the converter and watches `sclk` and `cs_n` on falling system clock edges. It drives each return bit right after the fall it sees, and it reads the control bits after each rise, so it never samples at an active edge. Expected tags and values are queued when a frame begins and compared with what comes out. Output stability is judged one cycle after each refusal of `smp_ready`. Timing of the divider is measured in whole system clocks between observed `sclk` rises.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W      = 3;
  localparam int DATA_W    = 12;
  localparam int LEAD_W    = 4;
  localparam int FRAME_LEN = LEAD_W + DATA_W;
  localparam int CTRL_W    = 8;
  localparam int ADDR_LSB  = 3;
  localparam int BITN_W    = $clog2(FRAME_LEN);

  typedef enum logic [1:0] {PH_IDLE, PH_GAP, PH_LO, PH_HI} phase_t;

  // control word: address field placed at ADDR_LSB, all other bits zero
  function automatic logic [CTRL_W-1:0] ctrl_word(input logic [CH_W-1:0] addr);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[ADDR_LSB +: CH_W] = addr;
    return w;
  endfunction

  // next table slot with wrap after the last used slot
  function automatic int unsigned next_slot(input int unsigned cur, input int unsigned last);
    return (cur >= last) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/adc_half_timer.sv
module adc_half_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_half,
  output logic             expire
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt == '0)  cnt <= div_half;
    else                 cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/adc_chan_tracker.sv
module adc_chan_tracker
  import adc_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      burst_start,
  input  logic                      frame_start,
  input  logic                      frame_done,
  input  logic [SLOT_W-1:0]         seq_len,
  input  logic [NUM_SLOTS*CH_W-1:0] seq_chans,
  output logic [CTRL_W-1:0]         ctrl,
  output logic [CH_W-1:0]           conv_chan
);
  logic [SLOT_W-1:0] ptr;
  logic [CH_W-1:0]   sent_addr;
  logic [CH_W-1:0]   slot_addr;

  assign slot_addr = seq_chans[ptr*CH_W +: CH_W];
  assign ctrl      = ctrl_word(slot_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      sent_addr <= '0;
      conv_chan <= '0;
    end else if (burst_start) begin
      ptr       <= '0;
      conv_chan <= '0;
    end else begin
      if (frame_start) begin
        sent_addr <= slot_addr;
        ptr       <= SLOT_W'(next_slot(32'(ptr), 32'(seq_len)));
      end
      if (frame_done) conv_chan <= sent_addr;
    end
  end
endmodule

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              expire,
  input  logic              enable,
  input  logic              out_busy,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              miso,
  output logic              cs_n,
  output logic              sclk,
  output logic              mosi,
  output logic              burst_start,
  output logic              frame_start,
  output logic              frame_done,
  output logic [DATA_W-1:0] rx_data
);
  phase_t            ph;
  logic [BITN_W-1:0] bitn;
  logic [CTRL_W-1:0] ctrl_sh;
  logic              last_bit;

  assign last_bit    = (bitn == BITN_W'(FRAME_LEN - 1));
  assign burst_start = expire && (ph == PH_IDLE) && enable;
  assign frame_start = expire && (ph == PH_GAP) && enable && !out_busy;
  assign frame_done  = expire && (ph == PH_HI) && last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      cs_n    <= 1'b1;
      sclk    <= 1'b1;
      mosi    <= 1'b0;
      bitn    <= '0;
      ctrl_sh <= '0;
      rx_data <= '0;
    end else if (expire) begin
      unique case (ph)
        PH_IDLE: if (enable) begin
          ph   <= PH_GAP;
          cs_n <= 1'b0;
        end
        PH_GAP: begin
          if (!enable) begin
            ph   <= PH_IDLE;
            cs_n <= 1'b1;
          end else if (!out_busy) begin
            ph      <= PH_LO;
            sclk    <= 1'b0;
            bitn    <= '0;
            mosi    <= ctrl[CTRL_W-1];
            ctrl_sh <= {ctrl[CTRL_W-2:0], 1'b0};
          end
        end
        PH_LO: begin
          ph      <= PH_HI;
          sclk    <= 1'b1;
          // 12-bit register: the four leading bits shift out the top
          rx_data <= {rx_data[DATA_W-2:0], miso};
        end
        PH_HI: begin
          if (last_bit) begin
            ph <= PH_GAP;
          end else begin
            ph      <= PH_LO;
            sclk    <= 1'b0;
            bitn    <= bitn + 1'b1;
            mosi    <= ctrl_sh[CTRL_W-1];
            ctrl_sh <= {ctrl_sh[CTRL_W-2:0], 1'b0};
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_host.sv
module adc_seq_host
  import adc_seq_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int NUM_SLOTS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          enable,
  input  logic [DIV_W-1:0]              div_half,
  input  logic [$clog2(NUM_SLOTS)-1:0]  seq_len,
  input  logic [NUM_SLOTS*CH_W-1:0]     seq_chans,
  input  logic                          miso,
  output logic                          cs_n,
  output logic                          sclk,
  output logic                          mosi,
  output logic                          smp_valid,
  input  logic                          smp_ready,
  output logic [DATA_W-1:0]             smp_data,
  output logic [CH_W-1:0]               smp_chan
);
  logic              expire;
  logic              burst_start;
  logic              frame_start;
  logic              frame_done;
  logic [CTRL_W-1:0] ctrl;
  logic [CH_W-1:0]   conv_chan;
  logic [DATA_W-1:0] rx_data;

  adc_half_timer #(.DIV_W(DIV_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_half (div_half),
    .expire   (expire)
  );

  adc_frame_engine u_engine (
    .clk         (clk),
    .rst_n       (rst_n),
    .expire      (expire),
    .enable      (enable),
    .out_busy    (smp_valid),
    .ctrl        (ctrl),
    .miso        (miso),
    .cs_n        (cs_n),
    .sclk        (sclk),
    .mosi        (mosi),
    .burst_start (burst_start),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .rx_data     (rx_data)
  );

  adc_chan_tracker #(.NUM_SLOTS(NUM_SLOTS)) u_tracker (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_start (burst_start),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .seq_len     (seq_len),
    .seq_chans   (seq_chans),
    .ctrl        (ctrl),
    .conv_chan   (conv_chan)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
      smp_chan  <= '0;
    end else if (frame_done) begin
      smp_valid <= 1'b1;
      smp_data  <= rx_data;
      smp_chan  <= conv_chan;
    end else if (smp_ready) begin
      smp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_seq_host_chk.sv
module adc_seq_host_chk
  import adc_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              sclk,
  input logic              mosi,
  input logic              smp_valid,
  input logic              smp_ready,
  input logic [DATA_W-1:0] smp_data,
  input logic [CH_W-1:0]   smp_chan,
  input logic              burst_start,
  input logic              frame_start,
  input logic              frame_done
);
  logic       sclk_q;
  logic       rise_now;
  logic [4:0] rises;
  logic       first_pend;

  assign rise_now = sclk && !sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b1;
      rises      <= '0;
      first_pend <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (frame_start)   rises <= '0;
      else if (rise_now) rises <= rises + 1'b1;
      if (burst_start)     first_pend <= 1'b1;
      else if (frame_done) first_pend <= 1'b0;
    end
  end

  AST_CS_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);                                                       // R1
  AST_FRAME_SIXTEEN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (5'(rises + {4'b0, rise_now}) == 5'd16) && !cs_n);     // R1
  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi) |-> $fell(sclk));                                      // R4
  AST_FIRST_CHAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && first_pend) |=> smp_valid && (smp_chan == '0));        // R6
  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> smp_valid && $stable(smp_data) && $stable(smp_chan)); // R9
  AST_NO_START_WHILE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !smp_valid);                                          // R9
endmodule

bind adc_seq_host adc_seq_host_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .sclk        (sclk),
  .mosi        (mosi),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .smp_data    (smp_data),
  .smp_chan    (smp_chan),
  .burst_start (burst_start),
  .frame_start (frame_start),
  .frame_done  (frame_done)
);

// File: tb/test_adc_seq_host.sv
module test_adc_seq_host;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [7:0]  div_half = 8'd1;
  logic [2:0]  seq_len = 3'd0;
  logic [23:0] seq_chans = '0;
  logic        miso = 1'b0;
  logic        smp_ready = 1'b0;
  logic        cs_n, sclk, mosi, smp_valid;
  logic [11:0] smp_data;
  logic [2:0]  smp_chan;

  always #2 clk = ~clk;

  adc_seq_host #(.DIV_W(8), .NUM_SLOTS(8)) i_adc_seq_host (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_half(div_half),
    .seq_len(seq_len), .seq_chans(seq_chans), .miso(miso),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_data(smp_data), .smp_chan(smp_chan)
  );

  int checks = 0, errors = 0;
  int mon_checks = 0, mon_errs = 0;
  bit ready_slow = 1'b0;

  function automatic logic [11:0] adc_val(input logic [2:0] c, input int n);
    return {c, n[8:0]} ^ 12'h5A5;
  endfunction

  // converter model and output scoreboard
  logic       prev_cs = 1'b1, prev_sclk = 1'b1;
  int         m_bit = 0, slot_exp = 0, m_frames = 0, acc_cnt = 0;
  logic [2:0] m_cur = '0;
  logic [7:0] m_ctrl = '0, exp_ctrl;
  logic [11:0] m_word = '0;
  logic [15:0] fw;
  bit         first_fr = 1'b0, mosi_bad = 1'b0, in_high = 1'b0;
  logic       mosi_rise = 1'b0;
  logic [2:0] exp_ch [64];
  logic [11:0] exp_d [64];
  bit         exp_first [64];
  int         wr = 0, rd = 0;
  logic [7:0] lfsr = 8'h5B;
  logic       last_valid = 1'b0, last_ready = 1'b0;
  logic [11:0] last_data = '0;
  logic [2:0] last_chan = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cs = 1'b1; prev_sclk = 1'b1; m_bit = 0; in_high = 1'b0;
      last_valid = 1'b0; smp_ready = 1'b0;
    end else begin
      // handshake stability from the previous cycle (R9)
      if (last_valid && !last_ready) begin
        mon_checks++;
        if (!(smp_valid && smp_data == last_data && smp_chan == last_chan)) begin
          mon_errs++;
          $display("FAIL R9 actual data %0d chan %0d expected data %0d chan %0d",
                   smp_data, smp_chan, last_data, last_chan);
        end
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      smp_ready = ready_slow ? (lfsr[0] & lfsr[1]) : 1'b1;
      if (smp_valid && smp_ready) begin
        mon_checks += 2;
        acc_cnt++;
        if (smp_chan != exp_ch[rd]) begin
          mon_errs++;
          $display("FAIL %s tag actual %0d expected %0d",
                   exp_first[rd] ? "R6" : "R7", smp_chan, exp_ch[rd]);
        end
        if (smp_data != exp_d[rd]) begin
          mon_errs++;
          $display("FAIL R5 data actual %0d expected %0d", smp_data, exp_d[rd]);
        end
        rd = (rd + 1) % 64;
      end
      last_valid = smp_valid; last_ready = smp_ready;
      last_data = smp_data; last_chan = smp_chan;

      // converter side
      if (prev_cs && !cs_n) begin
        m_cur = '0; m_bit = 0; slot_exp = 0; first_fr = 1'b1;
      end
      if (!prev_cs && cs_n) begin
        mon_checks++;
        in_high = 1'b0;
        if (m_bit != 0) begin
          mon_errs++;
          $display("FAIL R10 actual %0d cycles at select rise expected 0", m_bit);
        end
      end
      if (!cs_n && sclk && prev_sclk && in_high && (mosi !== mosi_rise)) mosi_bad = 1'b1;
      if (!cs_n && prev_sclk && !sclk) begin
        in_high = 1'b0;
        if (m_bit == 0) begin
          m_word = adc_val(m_cur, m_frames);
          exp_ch[wr] = m_cur; exp_d[wr] = m_word; exp_first[wr] = first_fr;
          wr = (wr + 1) % 64;
          first_fr = 1'b0; mosi_bad = 1'b0;
        end
        fw = {4'b0000, m_word};
        miso = fw[15 - m_bit];
      end
      if (!cs_n && !prev_sclk && sclk) begin
        in_high = 1'b1;
        mosi_rise = mosi;
        if (m_bit < 8) m_ctrl[7 - m_bit] = mosi;
        else if (mosi) mosi_bad = 1'b1;
        m_bit++;
        if (m_bit == 16) begin
          exp_ctrl = {2'b00, seq_chans[slot_exp*3 +: 3], 3'b000};
          mon_checks += 2;
          if (m_ctrl != exp_ctrl) begin
            mon_errs++;
            $display("FAIL R3 R8 control actual %0h expected %0h", m_ctrl, exp_ctrl);
          end
          if (mosi_bad) begin
            mon_errs++;
            $display("FAIL R4 actual mosi moved off a fall expected steady");
          end
          slot_exp = (slot_exp >= int'(seq_len)) ? 0 : slot_exp + 1;
          m_cur = m_ctrl[5:3];
          m_bit = 0;
          m_frames++;
        end
      end
      prev_cs = cs_n; prev_sclk = sclk;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_frames(input int n);
    int target;
    target = m_frames + n;
    enable = 1'b1;
    wait (m_frames >= target);
    enable = 1'b0;
    wait (cs_n == 1'b1);
    ready_slow = 1'b0;
    wait (rd == wr && !smp_valid);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R11 cs_n", int'(cs_n), 1);
    chk(sclk == 1'b1, "R11 sclk", int'(sclk), 1);
    chk(mosi == 1'b0 && smp_valid == 1'b0, "R11 mosi/valid", int'({mosi, smp_valid}), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b1, "R1 idle", int'({cs_n, sclk}), 3);
  endtask

  task automatic t_divider(input logic [7:0] d);
    int cyc, t_r1, t_f, t_r2;
    logic ps;
    div_half = d;
    enable = 1'b1;
    wait (cs_n == 1'b0);
    cyc = 0; t_r1 = -1; t_f = -1; t_r2 = -1; ps = sclk;
    while (t_r2 < 0) begin
      @(negedge clk);
      cyc++;
      if (!ps && sclk) begin
        if (t_r1 < 0) t_r1 = cyc; else t_r2 = cyc;
      end
      if (ps && !sclk && t_r1 >= 0 && t_f < 0) t_f = cyc;
      ps = sclk;
    end
    chk(t_r2 - t_r1 == 2 * (int'(d) + 1), "R2 period", t_r2 - t_r1, 2 * (int'(d) + 1));
    chk(t_f - t_r1 == int'(d) + 1, "R2 high phase", t_f - t_r1, int'(d) + 1);
    enable = 1'b0;
    wait (cs_n == 1'b1);
    wait (rd == wr && !smp_valid);
    repeat (4) @(negedge clk);
    div_half = 8'd1;
  endtask

  task automatic t_sequence();
    int a0;
    seq_chans = {12'd0, 3'd1, 3'd7, 3'd2, 3'd5};
    seq_len = 3'd3;
    a0 = acc_cnt;
    run_frames(9);
    chk(acc_cnt - a0 == 9, "R7 sample count", acc_cnt - a0, 9);
  endtask

  task automatic t_backpressure();
    int a0;
    seq_chans = {3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
    seq_len = 3'd7;
    ready_slow = 1'b1;
    a0 = acc_cnt;
    run_frames(12);
    chk(acc_cnt - a0 == 12, "R9 no sample lost", acc_cnt - a0, 12);
  endtask

  task automatic t_restart();
    int a0;
    seq_chans = {18'd0, 3'd6, 3'd3};
    seq_len = 3'd1;
    a0 = acc_cnt;
    run_frames(3);
    chk(acc_cnt - a0 == 3, "R8 restart count", acc_cnt - a0, 3);
    a0 = acc_cnt;
    run_frames(2);
    chk(acc_cnt - a0 == 2, "R6 second burst count", acc_cnt - a0, 2);
  endtask

  task automatic t_stop();
    int f0;
    bit held;
    enable = 1'b1;
    wait (m_bit >= 6);
    f0 = m_frames;
    enable = 1'b0;
    wait (cs_n == 1'b1);
    chk(m_frames == f0 + 1, "R10 frame completed", m_frames, f0 + 1);
    held = 1'b1;
    repeat (40) begin
      @(negedge clk);
      if (!(cs_n && sclk)) held = 1'b0;
    end
    chk(held, "R1 select stays high", int'(held), 1);
    wait (rd == wr && !smp_valid);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_divider(8'd3);
    t_divider(8'd0);
    t_sequence();
    t_backpressure();
    t_restart();
    t_stop();
    repeat (10) @(negedge clk);
    chk(mon_errs == 0, "R5 R7 monitor", mon_errs, 0);
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks, errors + mon_errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL R1 watchdog actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks + mon_checks + 1, errors + mon_errs + 1);
    $finish;
  end
endmodule